// File: doc/BRIEF.md
# SIMD Divergence Write-Mask Unit

This unit manages per-lane control flow for one group of shader invocations. All lanes of the group run on a SIMD datapath of `LANES` lanes and share one instruction stream and one program counter. The lane count is not visible to software. When a branch condition differs between lanes, the group executes every path that at least one lane takes, one path after another. A per-lane write mask gates register write-back, so lanes that are switched off change no state. If the group fully diverges, only one lane in `LANES` does useful work.

The decoder raises one of six control strobes: if, else, end-if, loop-begin, break and loop-end. Each strobe comes with a per-lane condition vector. The unit returns two things. The first is the write mask for the next instruction, which is registered. The second is a program-counter select for the current instruction, which is combinational: fall through, jump forward past a body, or go back to the loop head. Enclosing masks are kept on a stack that is `DEPTH` entries deep, so divergent constructs can nest up to that depth. A path that no active lane takes is skipped in the same cycle as the strobe.

Top module: `simd_div_mask`

## Requirements
- R1: After a synchronous active-low reset, the write mask is all ones, the stack is empty, the error flag is 0 and the PC select is 0 (fall through).
- R2: An if strobe with a stack that is not full pushes the current mask and the lanes that did not take the branch. On the next cycle the mask is the old mask AND cond.
- R3: The PC select encodes 0 = fall through, 1 = jump forward, 2 = back to loop head. An if strobe drives 1 in the same cycle when (mask AND cond) is zero, and 0 otherwise.
- R4: An else strobe sets the mask to the saved mask AND NOT the if-condition, taken from the top entry. It drives a PC select of 1 in the same cycle when that value is zero. It does not pop the stack.
- R5: An end-if strobe restores the saved mask from the top entry and pops that entry.
- R6: Constructs nest up to `DEPTH` levels, and each end-if restores the mask of the level that encloses it.
- R7: A loop-begin strobe pushes the current mask and leaves the mask unchanged.
- R8: A break strobe clears the lanes set in cond from the mask. It drives a PC select of 1 when the resulting mask is zero.
- R9: A loop-end strobe with a non-zero mask drives a PC select of 2 and keeps the mask. With a zero mask it restores the mask saved at loop entry, pops the entry and drives 0.
- R10: An if or loop-begin on a full stack, or an else, end-if or loop-end on an empty stack, sets a sticky error flag one cycle later. The mask and the stack stay unchanged and the PC select is 0. Only reset clears the flag.
- R11: When more than one strobe is high in a cycle, only one takes effect. The priority is if, else, end-if, loop-begin, break, loop-end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | LANES | Per-lane condition (branch taken or lane breaks) |
| if_i | input | 1 | If strobe |
| else_i | input | 1 | Else strobe |
| endif_i | input | 1 | End-if strobe |
| loop_i | input | 1 | Loop-begin strobe |
| brk_i | input | 1 | Break strobe |
| lend_i | input | 1 | Loop-end strobe |
| wmask_o | output | LANES | Write mask for the following instruction |
| pc_sel_o | output | 2 | Next-PC select: 0 fall through, 1 jump forward, 2 loop back |
| err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The PC select depends only on the current strobe, the condition and the state, so it is due in the same cycle as the strobe. The bench drives each strobe on a falling edge and samples the PC select 1 ns later. The write mask and the error flag pass through one register, so they are due after the next rising edge, and the bench reads them 1 ns after that edge, before the next stimulus. The bench uses an 8-lane, 3-deep configuration and sweeps every condition value through if/else/end-if, nested pairs, break-driven loop exits and both stack limits.

// File: rtl/simd_div_pkg.sv
// Shared types for the SIMD divergence write-mask unit.
// Assumes: at most one control operation takes effect per cycle.
package simd_div_pkg;

    // Next-PC select presented to the fetch stage
    typedef enum logic [1:0] {
        PC_SEQ  = 2'd0,
        PC_JUMP = 2'd1,
        PC_BACK = 2'd2
    } pc_sel_e;

    // Decoded control operation after strobe priority
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_IF    = 3'd1,
        OP_ELSE  = 3'd2,
        OP_ENDIF = 3'd3,
        OP_LOOP  = 3'd4,
        OP_BRK   = 3'd5,
        OP_LEND  = 3'd6
    } div_op_e;

endpackage

// File: rtl/simd_div_decode.sv
// Strobe decoder: reduces the six control strobes to one operation.
// Assumes: priority is if > else > end-if > loop > break > loop-end.
module simd_div_decode
    import simd_div_pkg::*;
(
    input  logic    if_i,
    input  logic    else_i,
    input  logic    endif_i,
    input  logic    loop_i,
    input  logic    brk_i,
    input  logic    lend_i,
    output div_op_e op_o
);

    // Fixed-priority selection of the effective operation
    always_comb begin
        if (if_i)         op_o = OP_IF;
        else if (else_i)  op_o = OP_ELSE;
        else if (endif_i) op_o = OP_ENDIF;
        else if (loop_i)  op_o = OP_LOOP;
        else if (brk_i)   op_o = OP_BRK;
        else if (lend_i)  op_o = OP_LEND;
        else              op_o = OP_NONE;
    end

endmodule

// File: rtl/simd_div_stack.sv
// Mask stack: each entry holds the enclosing mask and the lanes still pending
// for an else path. Assumes push and pop are never both high, and that the
// caller never pushes when full nor pops when empty.
module simd_div_stack #(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [LANES-1:0] push_saved_i,
    input  logic [LANES-1:0] push_pend_i,
    output logic [LANES-1:0] top_saved_o,
    output logic [LANES-1:0] top_pend_o,
    output logic             empty_o,
    output logic             full_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0]    cnt_q;
    logic [IW-1:0]    top_idx;
    logic [LANES-1:0] saved_q [DEPTH];
    logic [LANES-1:0] pend_q  [DEPTH];

    // Occupancy flags and top-of-stack index
    always_comb begin
        empty_o = (cnt_q == '0);
        full_o  = (cnt_q == CW'(DEPTH));
        top_idx = IW'(cnt_q - CW'(1));
    end

    // Read port for the top entry
    always_comb begin
        top_saved_o = saved_q[top_idx];
        top_pend_o  = pend_q[top_idx];
    end

    // Entry count
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (push_i) cnt_q <= cnt_q + CW'(1);
        else if (pop_i)  cnt_q <= cnt_q - CW'(1);
    end

    // One write port per entry, selected by the current count
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                saved_q[e] <= '0;
                pend_q[e]  <= '0;
            end else if (push_i && (cnt_q == CW'(e))) begin
                saved_q[e] <= push_saved_i;
                pend_q[e]  <= push_pend_i;
            end
        end
    end

endmodule

// File: rtl/simd_div_ctl.sv
// Mask controller: holds the live write mask and the sticky error flag,
// works out the next mask, the stack actions and the next-PC select.
// Assumes one decoded operation per cycle; a faulting operation is a no-op.
module simd_div_ctl
    import simd_div_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  div_op_e          op_i,
    input  logic [LANES-1:0] cond_i,
    input  logic [LANES-1:0] top_saved_i,
    input  logic [LANES-1:0] top_pend_i,
    input  logic             empty_i,
    input  logic             full_i,
    output logic             push_o,
    output logic             pop_o,
    output logic [LANES-1:0] push_saved_o,
    output logic [LANES-1:0] push_pend_o,
    output logic [LANES-1:0] mask_o,
    output pc_sel_e          pc_sel_o,
    output logic             fault_o,
    output logic             err_o
);

    logic [LANES-1:0] mask_q;
    logic [LANES-1:0] mask_d;
    logic             err_q;

    // Next-state and PC decisions for the current operation
    always_comb begin
        mask_d       = mask_q;
        push_o       = 1'b0;
        pop_o        = 1'b0;
        push_saved_o = mask_q;
        push_pend_o  = '0;
        pc_sel_o     = PC_SEQ;
        fault_o      = 1'b0;
        unique case (op_i)
            OP_IF: begin
                if (full_i) begin
                    fault_o = 1'b1;
                end else begin
                    push_o      = 1'b1;
                    push_pend_o = mask_q & ~cond_i;
                    mask_d      = mask_q & cond_i;
                    if ((mask_q & cond_i) == '0) pc_sel_o = PC_JUMP;
                end
            end
            OP_ELSE: begin
                if (empty_i) begin
                    fault_o = 1'b1;
                end else begin
                    mask_d = top_pend_i;
                    if (top_pend_i == '0) pc_sel_o = PC_JUMP;
                end
            end
            OP_ENDIF: begin
                if (empty_i) begin
                    fault_o = 1'b1;
                end else begin
                    mask_d = top_saved_i;
                    pop_o  = 1'b1;
                end
            end
            OP_LOOP: begin
                if (full_i) fault_o = 1'b1;
                else        push_o  = 1'b1;
            end
            OP_BRK: begin
                mask_d = mask_q & ~cond_i;
                if ((mask_q & ~cond_i) == '0) pc_sel_o = PC_JUMP;
            end
            OP_LEND: begin
                if (empty_i) begin
                    fault_o = 1'b1;
                end else if (mask_q != '0) begin
                    pc_sel_o = PC_BACK;
                end else begin
                    mask_d = top_saved_i;
                    pop_o  = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Live mask and sticky error register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            err_q  <= 1'b0;
        end else begin
            mask_q <= mask_d;
            err_q  <= err_q | fault_o;
        end
    end

    // Output drive
    always_comb begin
        mask_o = mask_q;
        err_o  = err_q;
    end

endmodule

// File: rtl/simd_div_mask.sv
// Top of the SIMD divergence write-mask unit: strobe decode, mask
// controller and mask stack. Assumes LANES >= 1 and DEPTH >= 2.
module simd_div_mask
    import simd_div_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] cond_i,
    input  logic             if_i,
    input  logic             else_i,
    input  logic             endif_i,
    input  logic             loop_i,
    input  logic             brk_i,
    input  logic             lend_i,
    output logic [LANES-1:0] wmask_o,
    output logic [1:0]       pc_sel_o,
    output logic             err_o
);

    div_op_e          op;
    pc_sel_e          pc_sel;
    logic             push, pop, empty, full, fault;
    logic [LANES-1:0] push_saved, push_pend, top_saved, top_pend;

    simd_div_decode u_dec (
        .if_i    (if_i),
        .else_i  (else_i),
        .endif_i (endif_i),
        .loop_i  (loop_i),
        .brk_i   (brk_i),
        .lend_i  (lend_i),
        .op_o    (op)
    );

    simd_div_ctl #(.LANES(LANES)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (op),
        .cond_i       (cond_i),
        .top_saved_i  (top_saved),
        .top_pend_i   (top_pend),
        .empty_i      (empty),
        .full_i       (full),
        .push_o       (push),
        .pop_o        (pop),
        .push_saved_o (push_saved),
        .push_pend_o  (push_pend),
        .mask_o       (wmask_o),
        .pc_sel_o     (pc_sel),
        .fault_o      (fault),
        .err_o        (err_o)
    );

    simd_div_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stk (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push),
        .pop_i        (pop),
        .push_saved_i (push_saved),
        .push_pend_i  (push_pend),
        .top_saved_o  (top_saved),
        .top_pend_o   (top_pend),
        .empty_o      (empty),
        .full_o       (full)
    );

    // PC select as a plain vector at the port
    always_comb pc_sel_o = pc_sel;

endmodule

// File: rtl/simd_div_mask_chk.sv
// Checker for simd_div_mask: temporal properties on ports and on the
// signals between decoder, controller and stack. Attached with bind.
module simd_div_mask_chk
    import simd_div_pkg::*;
#(
    parameter int LANES = 32
) (
    input logic             clk,
    input logic             rst_n,
    input div_op_e          op,
    input logic [LANES-1:0] cond_i,
    input logic [LANES-1:0] wmask_o,
    input logic [1:0]       pc_sel_o,
    input logic             err_o,
    input logic             fault,
    input logic             full,
    input logic             empty
);

    AST_IF_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IF && !full) |=> wmask_o == $past(wmask_o & cond_i)); // R2

    AST_IF_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IF && !full && (wmask_o & cond_i) == '0) |-> pc_sel_o == 2'd1); // R3

    AST_LOOP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOOP && !full) |=> $stable(wmask_o)); // R7

    AST_BRK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BRK) |=> wmask_o == $past(wmask_o & ~cond_i)); // R8

    AST_LOOP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LEND && !empty && wmask_o != '0) |-> pc_sel_o == 2'd2); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R10

    AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (err_o && $stable(wmask_o))); // R10

    AST_FAULT_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> pc_sel_o == 2'd0); // R10

endmodule

bind simd_div_mask simd_div_mask_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .cond_i   (cond_i),
    .wmask_o  (wmask_o),
    .pc_sel_o (pc_sel_o),
    .err_o    (err_o),
    .fault    (fault),
    .full     (full),
    .empty    (empty)
);

// File: tb/simd_div_mask_tb.sv
// Bench for simd_div_mask: 8 lanes, 3-deep stack, swept condition values.
// Expected values come from a requirement-level model held in the bench.
module simd_div_mask_tb_top;

    localparam int L = 8;
    localparam int D = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [L-1:0] cond_i = '0;
    logic         if_i = 0, else_i = 0, endif_i = 0, loop_i = 0, brk_i = 0, lend_i = 0;
    logic [L-1:0] wmask_o;
    logic [1:0]   pc_sel_o;
    logic         err_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    logic [L-1:0] m_mask;
    logic         m_err;
    logic [L-1:0] m_sav [D];
    logic [L-1:0] m_pnd [D];
    int           m_cnt;

    always #4 clk = ~clk;

    simd_div_mask #(.LANES(L), .DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i),
        .if_i(if_i), .else_i(else_i), .endif_i(endif_i),
        .loop_i(loop_i), .brk_i(brk_i), .lend_i(lend_i),
        .wmask_o(wmask_o), .pc_sel_o(pc_sel_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ops = {if, else, endif, loop, brk, lend}
    task automatic step(input logic [5:0] ops, input logic [L-1:0] c, input string tag);
        int           epc = 0;
        logic [L-1:0] nm  = m_mask;
        bit           flt = 0;
        if (ops[5]) begin
            if (m_cnt == D) flt = 1;
            else begin
                m_sav[m_cnt] = m_mask; m_pnd[m_cnt] = m_mask & ~c; m_cnt++;
                nm = m_mask & c; if (nm == '0) epc = 1;
            end
        end else if (ops[4]) begin
            if (m_cnt == 0) flt = 1;
            else begin nm = m_pnd[m_cnt-1]; if (nm == '0) epc = 1; end
        end else if (ops[3]) begin
            if (m_cnt == 0) flt = 1;
            else begin nm = m_sav[m_cnt-1]; m_cnt--; end
        end else if (ops[2]) begin
            if (m_cnt == D) flt = 1;
            else begin m_sav[m_cnt] = m_mask; m_pnd[m_cnt] = '0; m_cnt++; end
        end else if (ops[1]) begin
            nm = m_mask & ~c; if (nm == '0) epc = 1;
        end else if (ops[0]) begin
            if (m_cnt == 0) flt = 1;
            else if (m_mask != '0) epc = 2;
            else begin nm = m_sav[m_cnt-1]; m_cnt--; end
        end
        if (flt) m_err = 1;
        m_mask = nm;
        @(negedge clk);
        {if_i, else_i, endif_i, loop_i, brk_i, lend_i} = ops;
        cond_i = c;
        #1;
        chk({tag, " pc"}, int'(pc_sel_o), epc);
        @(posedge clk);
        #1;
        chk({tag, " mask"}, int'(wmask_o), int'(m_mask));
        chk({tag, " err"}, int'(err_o), int'(m_err));
        {if_i, else_i, endif_i, loop_i, brk_i, lend_i} = '0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1;
        m_mask = '1; m_err = 0; m_cnt = 0;
        chk("R1 reset mask", int'(wmask_o), 8'hFF);
        chk("R1 reset err", int'(err_o), 0);
        chk("R1 reset pc", int'(pc_sel_o), 0);
    endtask

    localparam logic [5:0] S_IF = 6'b100000, S_ELSE = 6'b010000, S_ENDIF = 6'b001000;
    localparam logic [5:0] S_LOOP = 6'b000100, S_BRK = 6'b000010, S_LEND = 6'b000001;

    initial begin
        do_reset();
        // R2 R3 R4 R5: single-level if/else/end-if over every condition
        for (int c = 0; c < 256; c++) begin
            step(S_IF, L'(c), "R2/R3 if");
            step(S_ELSE, '0, "R4 else");
            step(S_ENDIF, '0, "R5 endif");
        end
        // R6: two nested levels under selected outer/inner conditions
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(S_IF, L'(a * 17), "R6 outer if");
                step(S_IF, L'(b * 29), "R6 inner if");
                step(S_ELSE, '0, "R6 inner else");
                step(S_ENDIF, '0, "R6 inner endif");
                step(S_ELSE, '0, "R6 outer else");
                step(S_ENDIF, '0, "R6 outer endif");
            end
        end
        // R7 R8 R9: loop with two break rounds, inside a partial if
        for (int c = 0; c < 256; c++) begin
            step(S_IF, 8'h7E, "R2 guard if");
            step(S_LOOP, '0, "R7 loop begin");
            step(S_BRK, L'(c), "R8 break");
            step(S_LEND, '0, "R9 loop end");
            step(S_BRK, 8'hFF, "R8 break all");
            step(S_LEND, '0, "R9 loop exit");
            step(S_ENDIF, '0, "R5 guard endif");
        end
        // R11: simultaneous strobes follow priority
        step(6'b100011, 8'h0F, "R11 if wins");
        step(6'b011111, 8'h00, "R11 else wins");
        step(6'b000111, 8'hAA, "R11 loop wins");
        step(6'b000011, 8'h55, "R11 break wins");
        step(S_LEND, '0, "R11 loop end");
        step(S_LEND, '0, "R11 loop end");
        step(S_ENDIF, '0, "R11 endif");
        // R10: underflow on empty stack
        do_reset();
        step(S_ENDIF, '0, "R10 underflow endif");
        step(S_ELSE, '0, "R10 underflow else");
        step(S_LEND, '0, "R10 underflow lend");
        // R10: overflow on full stack, error stays set
        do_reset();
        step(S_IF, 8'hF0, "R10 fill");
        step(S_IF, 8'h30, "R10 fill");
        step(S_LOOP, '0, "R10 fill");
        step(S_IF, 8'h10, "R10 overflow if");
        step(S_LOOP, '0, "R10 overflow loop");
        step(S_BRK, 8'h00, "R10 sticky");
        step(S_LEND, '0, "R10 lend back");
        step(S_BRK, 8'hFF, "R10 break");
        step(S_LEND, '0, "R10 lend exit");
        step(S_ENDIF, '0, "R10 unwind");
        step(S_ENDIF, '0, "R10 unwind");
        do_reset();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule